// File: doc/BRIEF.md
# Host Report Register and Memory Access Handler

This block sits behind a USB human-interface function. It takes the four-byte output reports that the host sends and turns them into accesses. A report can target a bank of four 16-bit control registers, which the block holds itself. It can also target a 64-word configuration memory, which sits outside the block and is reached through a simple request/acknowledge port. The block builds a three-byte input report for every read. The first byte of that report names the source of the data and also carries live status: headphone presence, volume buttons and a sticky playback-mute flag.

Every completed access pulls an active-low interrupt to an external controller. The interrupt stays low until that controller signals that it has fetched the data. The register contents are brought out in parallel so that neighbouring logic can use them. Byte framing arrives already decoded from the USB side, as a valid strobe, a start-of-report marker and a data byte. USB packet handling and the memory's wire protocol belong to other blocks.

Top module: `hid_reg_access`

## Requirements
- R1: While reset is low the registers read 0x0000, 0xB000 and 0x0004 for indices 0 to 2. Index 3 reads 0x007F if `pkg_sel_i` is 1 and 0x003F if it is 0. `irq_no` is 1 and no report or memory request is active.
- R2: A report whose bytes are (32, low, high, addr) with addr in 0..3 loads {high,low} into that register. The new value appears on `regs_o` (register n at bits 16n+15:16n) one clock after the command is decoded, which is two clocks after the last byte.
- R3: A report (48, x, x, addr) with addr in 0..3 gives a one-cycle `rpt_valid_o` two clocks after its last byte. Byte 0 then has bit 5 (register source) set, byte 1 is the register's low byte and byte 2 is its high byte.
- R4: A report (64, low, high, addr) with addr in 0..63 raises `mem_req_o` with `mem_we_o`=1 and presents the address and {high,low}. All of these hold steady until `mem_ack_i`.
- R5: A report (80, x, x, addr) with addr in 0..63 reads the memory. After `mem_ack_i`, the report has byte 0 bit 6 (memory source) set and carries `mem_rdata_i` as its low and high bytes.
- R6: A command byte other than 32, 48, 64 or 80 has no effect. The same holds for a register address above 3 or a memory address above 63. In all these cases there is no report, no register change, no memory request and no interrupt.
- R7: Report byte 0 is laid out as {ctrl, mem, reg, headphone, mute, vol_down, vol_up, 0}. The ctrl bit is always 0 in this block. Headphone is 1 while `hp_sense_i` is 1. Each volume bit is 1 while its active-low button input is 0.
- R8: The mute bit becomes 1 on the clock where `mute_btn_ni` is first seen low. It stays 1 until a cycle with `rpt_taken_i`=1. A new press wins over a clear in the same cycle.
- R9: `irq_no` goes low when a register access is accepted or a memory access is acknowledged. It returns high on the clock after `ctl_ack_i`=1, unless a new access completes in that same cycle.
- R10: A command decoded while a memory access is outstanding is dropped.
- R11: A byte with `rpt_sop_i`=1 always starts a new report and discards any partly received one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkg_sel_i | input | 1 | Selects the reset value of register 3 |
| rpt_valid_i | input | 1 | Output-report byte strobe |
| rpt_sop_i | input | 1 | Marks byte 0 of an output report |
| rpt_byte_i | input | 8 | Output-report byte |
| vol_up_ni | input | 1 | Volume-up button, active low |
| vol_dn_ni | input | 1 | Volume-down button, active low |
| mute_btn_ni | input | 1 | Playback-mute button, active low |
| hp_sense_i | input | 1 | Headphone plugged in |
| rpt_taken_i | input | 1 | Host consumed the input report; clears mute |
| ctl_ack_i | input | 1 | External controller fetched the data |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 6 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_ack_i | input | 1 | Memory access done |
| mem_rdata_i | input | 16 | Memory read data, valid with acknowledge |
| regs_o | output | 64 | All four registers, register n at bits 16n+15:16n |
| rpt_valid_o | output | 1 | Input report ready, one cycle |
| rpt_b0_o | output | 8 | Report byte 0: source and status flags |
| rpt_b1_o | output | 8 | Report byte 1: data low |
| rpt_b2_o | output | 8 | Report byte 2: data high |
| irq_no | output | 1 | Interrupt to external controller, active low |

## Verification
The hardest case to reach is a command that arrives while a memory access is still outstanding. A command takes four byte clocks to assemble, so the bench slows its memory model's acknowledge to a dozen cycles. It then sends a register write right behind a memory write and checks that the register still holds its earlier value. Partial reports are produced by cutting a report off after two bytes and starting the next one with the start marker. The sticky mute flag is checked over two reads made with no consume pulse, and then after one.

// File: rtl/hid_acc_pkg.sv
package hid_acc_pkg;
  localparam int BYTE_W  = 8;
  localparam int DATA_W  = 16;
  localparam int RPT_LEN = 4;

  localparam logic [7:0] OP_REG_WR = 8'd32;
  localparam logic [7:0] OP_REG_RD = 8'd48;
  localparam logic [7:0] OP_MEM_WR = 8'd64;
  localparam logic [7:0] OP_MEM_RD = 8'd80;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [DATA_W-1:0] data;
    logic [BYTE_W-1:0] addr;
  } host_cmd_t;

  typedef struct packed {
    logic hp;
    logic mute;
    logic vdn;
    logic vup;
  } stat_flags_t;

  typedef enum logic {ST_IDLE, ST_MEM} seq_st_e;
endpackage

// File: rtl/hid_cmd_rx.sv
module hid_cmd_rx
  import hid_acc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              sop_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              cmd_vld_o,
  output host_cmd_t         cmd_o
);
  localparam int IDX_W = $clog2(RPT_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RPT_LEN - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] hold_q [RPT_LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      cmd_vld_o <= 1'b0;
      cmd_o     <= '0;
      for (int i = 0; i < RPT_LEN-1; i++) hold_q[i] <= '0;
    end else begin
      cmd_vld_o <= 1'b0;
      if (vld_i) begin
        if (sop_i) begin
          hold_q[0] <= byte_i;
          idx_q     <= IDX_W'(1);
        end else if (idx_q == LAST) begin
          cmd_o     <= '{op: hold_q[0], data: {hold_q[2], hold_q[1]}, addr: byte_i};
          cmd_vld_o <= 1'b1;
          idx_q     <= '0;
        end else begin
          hold_q[idx_q] <= byte_i;
          idx_q         <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  // at least RPT_LEN-1 bytes separate two decoded commands
  p_cmd_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |=> !cmd_vld_o);
endmodule

// File: rtl/hid_reg_bank.sv
module hid_reg_bank
  import hid_acc_pkg::*;
#(
  parameter int NREG = 4,
  localparam int RAW = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pkg_sel_i,
  input  logic                   we_i,
  input  logic [RAW-1:0]         waddr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [RAW-1:0]         raddr_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  function automatic logic [DATA_W-1:0] init_val(int idx, logic sel);
    case (idx)
      1:       return DATA_W'(16'hB000);
      2:       return DATA_W'(16'h0004);
      3:       return sel ? DATA_W'(16'h007F) : DATA_W'(16'h003F);
      default: return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        regs_q[g] <= init_val(g, pkg_sel_i);
      else if (we_i && waddr_i == RAW'(g)) regs_q[g] <= wdata_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  assign rdata_o = regs_q[raddr_i];

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));
endmodule

// File: rtl/hid_status_flags.sv
module hid_status_flags
  import hid_acc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        vol_up_ni,
  input  logic        vol_dn_ni,
  input  logic        mute_btn_ni,
  input  logic        hp_sense_i,
  input  logic        taken_i,
  output stat_flags_t flags_o
);
  logic btn_prev_q, mute_q, press;

  assign press = btn_prev_q && !mute_btn_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      btn_prev_q <= 1'b1;
      mute_q     <= 1'b0;
    end else begin
      btn_prev_q <= mute_btn_ni;
      if (press)        mute_q <= 1'b1;
      else if (taken_i) mute_q <= 1'b0;
    end
  end

  assign flags_o = '{hp: hp_sense_i, mute: mute_q, vdn: !vol_dn_ni, vup: !vol_up_ni};

  p_mute_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o.mute && !taken_i) |=> flags_o.mute);
  p_mute_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_i && !press) |=> !flags_o.mute);
endmodule

// File: rtl/hid_reg_access.sv
module hid_reg_access
  import hid_acc_pkg::*;
#(
  parameter int NREG      = 4,
  parameter int MEM_DEPTH = 64,
  localparam int RAW = $clog2(NREG),
  localparam int MAW = $clog2(MEM_DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pkg_sel_i,
  input  logic                   rpt_valid_i,
  input  logic                   rpt_sop_i,
  input  logic [7:0]             rpt_byte_i,
  input  logic                   vol_up_ni,
  input  logic                   vol_dn_ni,
  input  logic                   mute_btn_ni,
  input  logic                   hp_sense_i,
  input  logic                   rpt_taken_i,
  input  logic                   ctl_ack_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [MAW-1:0]         mem_addr_o,
  output logic [15:0]            mem_wdata_o,
  input  logic                   mem_ack_i,
  input  logic [15:0]            mem_rdata_i,
  output logic [NREG*16-1:0]     regs_o,
  output logic                   rpt_valid_o,
  output logic [7:0]             rpt_b0_o,
  output logic [7:0]             rpt_b1_o,
  output logic [7:0]             rpt_b2_o,
  output logic                   irq_no
);
  localparam logic [7:0] REG_LIM = 8'(NREG);
  localparam logic [8:0] MEM_LIM = 9'(MEM_DEPTH);

  logic        cmd_vld;
  host_cmd_t   cmd;
  stat_flags_t flags;
  logic [15:0] reg_rdata;
  seq_st_e     st_q;

  hid_cmd_rx i_rx (
    .clk_i, .rst_ni,
    .vld_i(rpt_valid_i), .sop_i(rpt_sop_i), .byte_i(rpt_byte_i),
    .cmd_vld_o(cmd_vld), .cmd_o(cmd)
  );

  hid_status_flags i_flags (
    .clk_i, .rst_ni,
    .vol_up_ni, .vol_dn_ni, .mute_btn_ni, .hp_sense_i,
    .taken_i(rpt_taken_i), .flags_o(flags)
  );

  // decode: only accepted when idle and address in range
  logic go, reg_ok, mem_ok, reg_wr, reg_rd, mem_acc;
  assign go      = cmd_vld && (st_q == ST_IDLE);
  assign reg_ok  = cmd.addr < REG_LIM;
  assign mem_ok  = {1'b0, cmd.addr} < MEM_LIM;
  assign reg_wr  = go && reg_ok && cmd.op == OP_REG_WR;
  assign reg_rd  = go && reg_ok && cmd.op == OP_REG_RD;
  assign mem_acc = go && mem_ok && (cmd.op == OP_MEM_WR || cmd.op == OP_MEM_RD);

  hid_reg_bank #(.NREG(NREG)) i_bank (
    .clk_i, .rst_ni, .pkg_sel_i,
    .we_i(reg_wr), .waddr_i(cmd.addr[RAW-1:0]), .wdata_i(cmd.data),
    .raddr_i(cmd.addr[RAW-1:0]), .rdata_o(reg_rdata), .regs_o
  );

  logic mem_done;
  assign mem_done = (st_q == ST_MEM) && mem_ack_i;

  function automatic logic [7:0] head(logic from_mem, stat_flags_t f);
    return {1'b0, from_mem, !from_mem, f.hp, f.mute, f.vdn, f.vup, 1'b0};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rpt_valid_o <= 1'b0;
      rpt_b0_o    <= '0;
      rpt_b1_o    <= '0;
      rpt_b2_o    <= '0;
      irq_no      <= 1'b1;
    end else begin
      rpt_valid_o <= 1'b0;
      if (ctl_ack_i) irq_no <= 1'b1;
      if (reg_wr || reg_rd || mem_done) irq_no <= 1'b0;
      if (reg_rd) begin
        rpt_valid_o <= 1'b1;
        rpt_b0_o    <= head(1'b0, flags);
        {rpt_b2_o, rpt_b1_o} <= reg_rdata;
      end
      if (mem_acc) begin
        st_q        <= ST_MEM;
        mem_req_o   <= 1'b1;
        mem_we_o    <= cmd.op == OP_MEM_WR;
        mem_addr_o  <= cmd.addr[MAW-1:0];
        mem_wdata_o <= cmd.data;
      end
      if (mem_done) begin
        st_q      <= ST_IDLE;
        mem_req_o <= 1'b0;
        if (!mem_we_o) begin
          rpt_valid_o <= 1'b1;
          rpt_b0_o    <= head(1'b1, flags);
          {rpt_b2_o, rpt_b1_o} <= mem_rdata_i;
        end
      end
    end
  end

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o)));
  p_src_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> (!rpt_b0_o[7] && !rpt_b0_o[0] && $countones(rpt_b0_o[6:5]) == 1));
  p_irq_rpt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> !irq_no);
  p_busy_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> !rpt_valid_o);
endmodule

// File: tb/test_hid_reg_access.sv
module test_hid_reg_access;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, pkg_sel, rv, rsop, vup_n, vdn_n, mute_n, hp, taken, cack;
  logic [7:0] rbyte;
  logic mreq, mwe, mack;
  logic [5:0] maddr;
  logic [15:0] mwdata, mrdata;
  logic [63:0] regs;
  logic ov;
  logic [7:0] b0, b1, b2;
  logic irq_n;

  hid_reg_access i_hid_reg_access (
    .clk_i(clk), .rst_ni, .pkg_sel_i(pkg_sel),
    .rpt_valid_i(rv), .rpt_sop_i(rsop), .rpt_byte_i(rbyte),
    .vol_up_ni(vup_n), .vol_dn_ni(vdn_n), .mute_btn_ni(mute_n), .hp_sense_i(hp),
    .rpt_taken_i(taken), .ctl_ack_i(cack),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_ack_i(mack), .mem_rdata_i(mrdata),
    .regs_o(regs), .rpt_valid_o(ov), .rpt_b0_o(b0), .rpt_b1_o(b1), .rpt_b2_o(b2),
    .irq_no(irq_n)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, rpt_cnt = 0, lat = 3, lat_cnt = 0;
  logic [7:0] lb0, lb1, lb2;
  logic [15:0] bmem [64];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  // report monitor and memory model, both away from the active edge
  always @(negedge clk) begin
    if (ov) begin rpt_cnt++; lb0 = b0; lb1 = b1; lb2 = b2; end
    if (!rst_ni) begin mack = 1'b0; lat_cnt = 0; end
    else if (mack) mack = 1'b0;
    else if (mreq) begin
      if (lat_cnt >= lat) begin
        mack = 1'b1; mrdata = bmem[maddr]; lat_cnt = 0;
        if (mwe) bmem[maddr] = mwdata;
      end else lat_cnt++;
    end
  end

  task automatic send(logic [7:0] op, logic [7:0] lo, logic [7:0] hi, logic [7:0] ad);
    logic [7:0] bs [4];
    bs[0] = op; bs[1] = lo; bs[2] = hi; bs[3] = ad;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rv = 1'b1; rsop = (i == 0); rbyte = bs[i];
    end
    @(negedge clk); rv = 1'b0; rsop = 1'b0;
  endtask

  // {op, lo, hi, addr, report expected, b0, b1, b2}
  localparam int NV = 15;
  localparam logic [56:0] TBL [NV] = '{
    {8'd48, 8'h00, 8'h00, 8'd1,  1'b1, 8'h20, 8'h00, 8'hB0}, // R1 R3
    {8'd48, 8'h00, 8'h00, 8'd2,  1'b1, 8'h20, 8'h04, 8'h00}, // R1 R3
    {8'd32, 8'h34, 8'h12, 8'd0,  1'b0, 8'h00, 8'h00, 8'h00}, // R2
    {8'd48, 8'h00, 8'h00, 8'd0,  1'b1, 8'h20, 8'h34, 8'h12}, // R2 R3
    {8'd32, 8'h5A, 8'hA5, 8'd3,  1'b0, 8'h00, 8'h00, 8'h00}, // R2
    {8'd48, 8'h00, 8'h00, 8'd3,  1'b1, 8'h20, 8'h5A, 8'hA5}, // R2 R3
    {8'h99, 8'h00, 8'h00, 8'd0,  1'b0, 8'h00, 8'h00, 8'h00}, // R6 unknown op
    {8'd32, 8'hFF, 8'hFF, 8'd5,  1'b0, 8'h00, 8'h00, 8'h00}, // R6 reg addr 5
    {8'd48, 8'h00, 8'h00, 8'd0,  1'b1, 8'h20, 8'h34, 8'h12}, // R6
    {8'd48, 8'h00, 8'h00, 8'd1,  1'b1, 8'h20, 8'h00, 8'hB0}, // R6
    {8'd64, 8'hEF, 8'hBE, 8'd7,  1'b0, 8'h00, 8'h00, 8'h00}, // R4
    {8'd80, 8'h00, 8'h00, 8'd7,  1'b1, 8'h40, 8'hEF, 8'hBE}, // R4 R5
    {8'd80, 8'h00, 8'h00, 8'd63, 1'b1, 8'h40, 8'h3F, 8'h50}, // R5 top address
    {8'd64, 8'hAD, 8'hDE, 8'd64, 1'b0, 8'h00, 8'h00, 8'h00}, // R6 mem addr 64
    {8'd80, 8'h00, 8'h00, 8'd0,  1'b1, 8'h40, 8'h00, 8'h50}  // R6 no alias to 0
  };

  initial begin
    for (int i = 0; i < 64; i++) bmem[i] = 16'h5000 + 16'(i);
    rst_ni = 1'b0; pkg_sel = 1'b0; rv = 1'b0; rsop = 1'b0; rbyte = '0;
    vup_n = 1'b1; vdn_n = 1'b1; mute_n = 1'b1; hp = 1'b0; taken = 1'b0; cack = 1'b0;
    mack = 1'b0; mrdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 regs pkg0", regs[63:32], 32'h003F0004);
    chk("R1 regs pkg0 low", regs[31:0], 32'hB0000000);
    chk("R1 idle outputs", {31'b0, irq_n}, {31'b0, 1'b1});
    chk("R1 no activity", {30'b0, ov, mreq}, 32'h0);
    pkg_sel = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reg3 pkg1", {16'h0, regs[63:48]}, 32'h007F);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      rpt_cnt = 0;
      send(TBL[v][56:49], TBL[v][48:41], TBL[v][40:33], TBL[v][32:25]);
      repeat (20) @(negedge clk);
      chk($sformatf("R3/R5/R6 vec %0d report count", v), rpt_cnt, {31'b0, TBL[v][24]});
      if (TBL[v][24])
        chk($sformatf("R3/R5/R7 vec %0d bytes", v), {8'h0, lb0, lb1, lb2}, {8'h0, TBL[v][23:0]});
    end

    // R2/R3 exact timing
    send(8'd32, 8'h22, 8'h11, 8'd2);
    chk("R2 not before", {16'h0, regs[47:32]}, 32'h0004);
    @(negedge clk);
    chk("R2 update cycle", {16'h0, regs[47:32]}, 32'h1122);
    send(8'd48, 8'h00, 8'h00, 8'd2);
    chk("R3 no early report", {31'b0, ov}, 32'h0);
    @(negedge clk);
    chk("R3 report cycle", {7'b0, ov, b0, b1, b2}, {7'b0, 1'b1, 8'h20, 8'h22, 8'h11});

    // R9 interrupt release and re-arm
    @(negedge clk); cack = 1'b1;
    @(negedge clk); cack = 1'b0;
    chk("R9 released", {31'b0, irq_n}, 32'h1);
    rpt_cnt = 0;
    send(8'd33, 8'h00, 8'h00, 8'd0);
    repeat (5) @(negedge clk);
    chk("R6 unknown op no irq", {31'b0, irq_n}, 32'h1);
    chk("R6 unknown op no report", rpt_cnt, 0);
    send(8'd48, 8'h00, 8'h00, 8'd0);
    @(negedge clk);
    chk("R9 asserted", {31'b0, irq_n}, 32'h0);

    // R7 live status bits
    hp = 1'b1; vdn_n = 1'b0; vup_n = 1'b0;
    send(8'd48, 8'h00, 8'h00, 8'd1);
    @(negedge clk);
    chk("R7 flags", {24'h0, b0}, 32'h36);
    hp = 1'b0; vdn_n = 1'b1; vup_n = 1'b1;

    // R8 sticky mute
    @(negedge clk); mute_n = 1'b0;
    @(negedge clk); mute_n = 1'b1;
    send(8'd48, 8'h00, 8'h00, 8'd1);
    @(negedge clk);
    chk("R8 mute set", {24'h0, b0}, 32'h28);
    send(8'd48, 8'h00, 8'h00, 8'd1);
    @(negedge clk);
    chk("R8 mute sticky", {24'h0, b0}, 32'h28);
    @(negedge clk); taken = 1'b1;
    @(negedge clk); taken = 1'b0;
    send(8'd48, 8'h00, 8'h00, 8'd1);
    @(negedge clk);
    chk("R8 mute cleared", {24'h0, b0}, 32'h20);

    // R10 command during slow memory access
    lat = 12;
    send(8'd64, 8'h11, 8'h11, 8'd9);
    send(8'd32, 8'h77, 8'h77, 8'd0);
    repeat (30) @(negedge clk);
    chk("R10 dropped write", {16'h0, regs[15:0]}, 32'h1234);
    lat = 3;
    rpt_cnt = 0;
    send(8'd80, 8'h00, 8'h00, 8'd9);
    repeat (20) @(negedge clk);
    chk("R4 mem written during R10", {16'h0, lb2, lb1}, 32'h1111);

    // R11 resync on start marker
    rpt_cnt = 0;
    @(negedge clk); rv = 1'b1; rsop = 1'b1; rbyte = 8'd48;
    @(negedge clk); rsop = 1'b0; rbyte = 8'h00;
    send(8'd48, 8'h00, 8'h00, 8'd3);
    repeat (10) @(negedge clk);
    chk("R11 one report", rpt_cnt, 1);
    chk("R11 data", {16'h0, lb2, lb1}, 32'hA55A);

    finish_run();
  end
endmodule